// File: doc/BRIEF.md
# I2C Register-Bank Slave

This block is a synchronous I2C-compatible slave that lets a bus master read and write a bank of 8-bit registers. SCL and SDA are sampled by the system clock through two-flop synchronizers, and start and stop conditions are decoded from those samples. The slave answers to one 7-bit device address. Bit 1 of that address comes from a strap input, so two of these slaves can share one bus. SDA is driven open-drain: the block only ever pulls the line low, through an enable output.

A write transfer has three parts. The device address byte comes first, then a byte that selects the starting register, and then any number of data bytes. Each data byte goes into the selected register, and the register pointer then advances by one. A read starts from the pointer left by an earlier write, usually a write of the register index alone. A repeated start and the address byte with the read bit set follow it. Subaddresses that name no register are refused. At the top of the bank, reads keep returning the last register, while writes are refused and dropped.

The rest of the design reads the registers through a plain index-in, data-out side port. There are no valid/ready handshakes on this block: the bus side is paced by the master's SCL, and the side port is a combinational lookup that is always available.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset, sda_oe is 0 (line released) and every register reads 0 through the side port.
- R2: The device address is {BASE_ADDR[6:2], addr_strap, BASE_ADDR[0]}, sent MSB first and followed by a direction bit (1 = read, 0 = write). On a match the slave pulls SDA low for the ninth clock. On a mismatch it leaves SDA released for that clock and for the rest of the transfer.
- R3: In a write, the second byte sets the register pointer. Each following byte is stored at the pointer, acknowledged, and the pointer then increments.
- R4: A subaddress byte of NUM_REGS or more is not acknowledged. The slave goes idle, and the bytes that follow are neither stored nor acknowledged.
- R5: A write byte that arrives when the pointer has passed the last register (NUM_REGS-1) is not stored anywhere, including register 0. It is not acknowledged, and the slave goes idle.
- R6: After a repeated start with the read bit set, the slave sends the register at the pointer MSB first. On each master acknowledge it sends the next register.
- R7: Reads past the last register keep returning register NUM_REGS-1. A master not-acknowledge (SDA high on the ninth clock) ends the read, and the slave leaves SDA released.
- R8: A stop at any point returns the slave to idle, and a partly received data byte is never stored. A start at any point restarts address reception.
- R9: The slave starts pulling SDA low only while SCL is low. It releases SDA at once on a start or stop.
- R10: side_data shows the register selected by side_idx in the same cycle, and reads 0 for an index of NUM_REGS or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| addr_strap | input | 1 | Level for device address bit 1 |
| side_idx | input | $clog2(NUM_REGS) | Register index for the side read port |
| side_data | output | 8 | Contents of the register at side_idx |

## Verification
The assertions assume a well-behaved master. It moves SDA only while SCL is low, except when it makes a start or stop. It also holds each SCL level for longer than the synchronizer delay, so every edge is seen exactly once and in order. The bench master drives in quarter-bit steps of 20 system clocks and changes data only a full quarter after SCL falls. It always ends a read with a not-acknowledge before it issues a stop. The abort cases break off transfers only at SCL-low points, so they stay within these rules.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_ACKDEV,
    ST_SUBADDR,
    ST_ACKSUB,
    ST_WDATA,
    ST_ACKWR,
    ST_RDATA,
    ST_RACK
  } xfer_state_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
  parameter int NUM_REGS = 16,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] ridx_a,
  output logic [7:0]       rdata_a,
  input  logic [IDX_W-1:0] ridx_b,
  output logic [7:0]       rdata_b
);
  logic [7:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem[g] <= 8'h00;
      else if (we && widx == IDX_W'(g))    mem[g] <= wdata;
    end
  end

  always_comb begin
    rdata_a = (32'(ridx_a) < NUM_REGS) ? mem[ridx_a] : 8'h00;
    rdata_b = (32'(ridx_b) < NUM_REGS) ? mem[ridx_b] : 8'h00;
  end
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
  import i2cs_pkg::*;
#(
  parameter int          NUM_REGS    = 16,
  parameter logic [6:0]  BASE_ADDR   = 7'h68,
  parameter int          SYNC_STAGES = 2,
  localparam int         IDX_W       = $clog2(NUM_REGS),
  localparam int         PTR_W       = $clog2(NUM_REGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic             addr_strap,
  input  logic [IDX_W-1:0] side_idx,
  output logic [7:0]       side_data
);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);
  localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(NUM_REGS - 1);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  i2cs_bus_events u_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  xfer_state_e      state;
  logic [3:0]       bit_cnt;
  logic [7:0]       rx_sr;
  logic [7:0]       tx_sr;
  logic [PTR_W-1:0] ptr;
  logic             rw_q;
  logic             master_nack;

  logic [6:0]       dev_addr;
  logic             ptr_ok;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_bus;
  logic             wr_en;

  assign dev_addr = {BASE_ADDR[6:2], addr_strap, BASE_ADDR[0]};
  assign ptr_ok   = ptr < PTR_END;
  assign rd_idx   = ptr_ok ? ptr[IDX_W-1:0] : PTR_TOP[IDX_W-1:0];
  assign wr_en    = (state == ST_WDATA) && scl_fall && (bit_cnt == 4'd8) && ptr_ok;

  i2cs_regfile #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en), .widx(ptr[IDX_W-1:0]), .wdata(rx_sr),
    .ridx_a(rd_idx), .rdata_a(rd_bus),
    .ridx_b(side_idx), .rdata_b(side_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      bit_cnt     <= '0;
      rx_sr       <= '0;
      tx_sr       <= '0;
      ptr         <= '0;
      rw_q        <= 1'b0;
      master_nack <= 1'b0;
      sda_oe      <= 1'b0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      state   <= ST_DEVADDR;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        ST_DEVADDR, ST_SUBADDR, ST_WDATA: begin
          if (scl_rise) begin
            rx_sr   <= {rx_sr[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            bit_cnt <= '0;
            if (state == ST_DEVADDR) begin
              if (rx_sr[7:1] == dev_addr) begin
                rw_q   <= rx_sr[0];
                state  <= ST_ACKDEV;
                sda_oe <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_SUBADDR) begin
              if (32'(rx_sr) < NUM_REGS) begin
                ptr    <= PTR_W'(rx_sr);
                state  <= ST_ACKSUB;
                sda_oe <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              if (ptr_ok) begin
                ptr    <= ptr + 1'b1;
                state  <= ST_ACKWR;
                sda_oe <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
        end
        ST_ACKDEV: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_q) begin
              state  <= ST_RDATA;
              tx_sr  <= rd_bus;
              sda_oe <= ~rd_bus[7];
            end else begin
              state  <= ST_SUBADDR;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_ACKSUB, ST_ACKWR: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            state   <= ST_WDATA;
            sda_oe  <= 1'b0;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
              if (ptr < PTR_TOP) ptr <= ptr + 1'b1;
            end else begin
              tx_sr  <= {tx_sr[6:0], 1'b0};
              sda_oe <= ~tx_sr[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            master_nack <= sda_s;
          end else if (scl_fall) begin
            bit_cnt <= '0;
            if (!master_nack) begin
              state  <= ST_RDATA;
              tx_sr  <= rd_bus;
              sda_oe <= ~rd_bus[7];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
  import i2cs_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int PTR_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input xfer_state_e      state,
  input logic             start_ev,
  input logic             stop_ev,
  input logic             scl_s,
  input logic             sda_oe,
  input logic [PTR_W-1:0] ptr
);
  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE && !sda_oe));

  assert_start_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state == ST_DEVADDR && !sda_oe));

  assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr) <= NUM_REGS);

  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);
endmodule

bind i2c_regbank_slave i2cs_checker #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .start_ev(start_ev),
  .stop_ev(stop_ev), .scl_s(scl_s), .sda_oe(sda_oe), .ptr(ptr)
);

// File: tb/tb_i2c_regbank_slave.sv
module tb_i2c_regbank_slave;
  localparam int NREG = 16;
  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       strap = 1'b1;
  logic [3:0] side_idx = '0;
  logic [7:0] side_data;
  logic       sda_oe;
  logic       sda_line;

  assign sda_line = sda_m & ~sda_oe;

  i2c_regbank_slave #(.NUM_REGS(NREG), .BASE_ADDR(7'h68)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_strap(strap), .side_idx(side_idx), .side_data(side_data)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string tag_q[$];
  int obs_q[$];
  int r9_viol = 0;
  logic oe_prev = 1'b0;

  task automatic expect_item(input int v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // monitor: pops observed results and compares with the scoreboard
  initial forever begin
    @(negedge clk);
    while (obs_q.size() > 0) begin
      int o;
      o = obs_q.pop_front();
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected result: actual %0h expected none", o);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (o != e) begin
          errors++;
          $display("FAIL %s: actual %0h expected %0h", t, o, e);
        end
      end
    end
  end

  // R9 watch: the slave must never start pulling SDA while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl) r9_viol++;
    oe_prev <= sda_oe;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    sda_m = 1'b0; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(Q);
    scl = 1'b1; wq(2 * Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    b = sda_line; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic wr_byte(input logic [7:0] v, input logic exp_ack, input string tag);
    logic a;
    expect_item(int'(exp_ack), tag);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(a);
    obs_q.push_back(int'(a));
  endtask

  task automatic rd_byte(input logic [7:0] exp_v, input logic m_ack, input string tag);
    logic [7:0] v;
    logic b;
    expect_item(int'(exp_v), tag);
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    obs_q.push_back(int'(v));
    send_bit(m_ack);
  endtask

  task automatic side_chk(input int idx, input logic [7:0] exp_v, input string tag);
    side_idx = 4'(idx);
    wq(2);
    expect_item(int'(exp_v), tag);
    obs_q.push_back(int'(side_data));
  endtask

  task automatic oe_chk(input string tag);
    expect_item(0, tag);
    obs_q.push_back(int'(sda_oe));
  endtask

  task automatic finish_run();
    wq(10);
    if (exp_q.size() > 0) begin
      errors += exp_q.size();
      $display("FAIL %0d expected results never observed: actual 0 expected %0d",
               exp_q.size(), exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wq(5);
    rst_n = 1'b1;
    wq(5);

    // R1 reset state
    oe_chk("R1 sda_oe after reset");
    for (int i = 0; i < NREG; i++) side_chk(i, 8'h00, "R1 register cleared");

    // R2 wrong address (strap=1 -> device 0x6A, 0x68 must not answer)
    bus_start();
    wr_byte(8'hD0, 1'b1, "R2 mismatch address not acked");
    wr_byte(8'h02, 1'b1, "R2 mismatch stays idle");
    bus_stop();

    // R3 multi-byte write
    bus_start();
    wr_byte(8'hD4, 1'b0, "R2 matching address acked");
    wr_byte(8'h02, 1'b0, "R3 subaddress acked");
    wr_byte(8'hA5, 1'b0, "R3 data acked");
    wr_byte(8'h3C, 1'b0, "R3 data acked");
    wr_byte(8'h7E, 1'b0, "R3 data acked");
    bus_stop();
    side_chk(2, 8'hA5, "R3 reg2");
    side_chk(3, 8'h3C, "R3 reg3");
    side_chk(4, 8'h7E, "R3 reg4");
    side_chk(5, 8'h00, "R10 reg5 untouched");

    // R6 read with repeated start
    bus_start();
    wr_byte(8'hD4, 1'b0, "R6 address acked");
    wr_byte(8'h02, 1'b0, "R6 subaddress acked");
    bus_start();
    wr_byte(8'hD5, 1'b0, "R6 read address acked");
    rd_byte(8'hA5, 1'b0, "R6 read reg2");
    rd_byte(8'h3C, 1'b0, "R6 read reg3");
    rd_byte(8'h7E, 1'b1, "R6 read reg4");
    bus_stop();

    // R4 invalid subaddress
    bus_start();
    wr_byte(8'hD4, 1'b0, "R4 address acked");
    wr_byte(8'h10, 1'b1, "R4 invalid subaddress nacked");
    wr_byte(8'h11, 1'b1, "R4 following byte nacked");
    bus_stop();
    side_chk(0, 8'h00, "R4 reg0 unchanged");
    side_chk(2, 8'hA5, "R4 reg2 unchanged");

    // R5 write past the top register
    bus_start();
    wr_byte(8'hD4, 1'b0, "R5 address acked");
    wr_byte(8'h0E, 1'b0, "R5 subaddress 14 acked");
    wr_byte(8'h11, 1'b0, "R5 reg14 write acked");
    wr_byte(8'h22, 1'b0, "R5 reg15 write acked");
    wr_byte(8'h33, 1'b1, "R5 past-end write nacked");
    wr_byte(8'h44, 1'b1, "R5 idle after past-end");
    bus_stop();
    side_chk(14, 8'h11, "R5 reg14");
    side_chk(15, 8'h22, "R5 reg15");
    side_chk(0, 8'h00, "R5 no wrap to reg0");

    // R7 read past the top register
    bus_start();
    wr_byte(8'hD4, 1'b0, "R7 address acked");
    wr_byte(8'h0E, 1'b0, "R7 subaddress acked");
    bus_start();
    wr_byte(8'hD5, 1'b0, "R7 read address acked");
    rd_byte(8'h11, 1'b0, "R7 reg14");
    rd_byte(8'h22, 1'b0, "R7 reg15");
    rd_byte(8'h22, 1'b0, "R7 top repeated");
    rd_byte(8'h22, 1'b1, "R7 top repeated again");
    wq(Q);
    oe_chk("R7 released after master nack");
    bus_stop();

    // R8 stop in the middle of a data byte
    bus_start();
    wr_byte(8'hD4, 1'b0, "R8 address acked");
    wr_byte(8'h05, 1'b0, "R8 subaddress acked");
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    oe_chk("R8 released after stop");
    side_chk(5, 8'h00, "R8 partial byte not stored");

    // R8 start in the middle of a data byte
    bus_start();
    wr_byte(8'hD4, 1'b0, "R8 address acked");
    wr_byte(8'h06, 1'b0, "R8 subaddress acked");
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_start();
    wr_byte(8'hD4, 1'b0, "R8 restart address acked");
    wr_byte(8'h06, 1'b0, "R8 restart subaddress acked");
    wr_byte(8'h99, 1'b0, "R8 restart data acked");
    bus_stop();
    side_chk(6, 8'h99, "R8 reg6 after restart");
    side_chk(5, 8'h00, "R8 reg5 still clear");

    // R2 strap low selects the other address
    strap = 1'b0;
    wq(4);
    bus_start();
    wr_byte(8'hD4, 1'b1, "R2 old address with strap low");
    bus_stop();
    bus_start();
    wr_byte(8'hD0, 1'b0, "R2 strap-low address acked");
    wr_byte(8'h07, 1'b0, "R2 subaddress acked");
    wr_byte(8'h5A, 1'b0, "R2 data acked");
    bus_stop();
    side_chk(7, 8'h5A, "R10 reg7 via side port");

    // R9 timing of SDA drive
    expect_item(0, "R9 drive started while SCL high");
    obs_q.push_back(r9_viol);

    finish_run();
  end
endmodule